// File: doc/BRIEF.md
# Compressed Bus Request Encoder

This block sits on the host side of a byte-serial bus bridge. It takes one bus access request at a time (a 32-bit address, a 16-bit write word, a write flag and a post-increment flag) and turns it into a short stream of bytes. The stream starts with a command byte. The fewest address bytes needed come next, and for a write the data bytes come last. The remote bridge holds an address register that keeps its value from one request to the next. The encoder keeps a shadow copy of that register, so it only sends the low-order address bytes that actually change.

Before each request the encoder compares the target address against two bases: the shadow copy and zero. The address phase is the shortest of 0, 1, 2 or 4 bytes that covers every byte that differs. When starting from zero needs fewer bytes than starting from the shadow, the command's clear flag is set. After a request with post-increment, the low byte of the shadow steps by one and wraps inside that byte. After reset the shadow is unknown, so the first request always clears.

Top module: `bus_req_encoder`

## Requirements
- R1: The command byte carries clear in bit 0, write in bit 1 and post-increment in bit 2. Bits 4:3 hold the length code, and bits 7:5 are always zero.
- R2: The number of address bytes that follow the command is set by the length code: 0 gives none, 1 gives one byte, 2 gives two bytes and 3 gives four bytes.
- R3: Address bytes are sent most significant first. When a remote register applies them (after clearing it if bit 0 is set, then replacing only its low-order bytes), it must hold exactly the requested address.
- R4: The first request after reset has the clear bit set.
- R5: Without clear, the length is the smallest of 0, 1, 2 or 4 bytes that covers every byte in which the request address differs from the shadow.
- R6: Clear is set, with the zero-based length, only when the zero-based length is strictly shorter than the shadow-based one.
- R7: After a post-increment request, the shadow low byte is the request's low byte plus one, wrapping within 8 bits. Bits 31:8 take the request address unchanged.
- R8: A write is followed by two data bytes, most significant first, after the address bytes. A read has no data bytes.
- R9: req_ready is high only when no byte is waiting. A new request is accepted only after the last byte of the previous one has been taken.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable on the next cycle.
- R11: A synchronous reset invalidates the shadow. The next request then clears, even if its address equals the old shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Encoder can accept a request |
| req_addr | input | 32 | Target bus address |
| req_wdata | input | 16 | Write data word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_postinc | input | 1 | Step the remote low address byte after the access |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |

## Verification
The checker assertions cover the properties that hold on every cycle:
- the zero reserved bits of each command byte;
- the write flag matching the accepted request;
- clear on the first command after reset;
- the byte count implied by each command;
- no acceptance while bytes are pending;
- stable output under back-pressure.

Some results depend on the history of earlier requests, so only the bench's scenarios can show them. These are whether the chosen length is the shortest one, when clear is preferred, the low-byte wrap after post-increment, and the loss of the shadow across a reset. For each request, the bench decodes the emitted bytes into a model of the remote register and compares the result with the intended address.

// File: rtl/bre_pkg.sv
package bre_pkg;
    localparam int ADDR_W = 32;
    localparam int CMD_W  = 8;

    typedef enum logic [1:0] {
        LEN_NONE = 2'd0,
        LEN_ONE  = 2'd1,
        LEN_TWO  = 2'd2,
        LEN_FOUR = 2'd3
    } len_code_e;

    function automatic logic [2:0] len_bytes(input len_code_e c);
        case (c)
            LEN_NONE: return 3'd0;
            LEN_ONE:  return 3'd1;
            LEN_TWO:  return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/bre_span.sv
// Smallest address-phase code that makes base equal to target.
module bre_span
    import bre_pkg::*;
(
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] base,
    output len_code_e         code
);
    logic [ADDR_W-1:0] diff;

    always_comb begin
        diff = target ^ base;
        if (|diff[31:16])     code = LEN_FOUR;
        else if (|diff[15:8]) code = LEN_TWO;
        else if (|diff[7:0])  code = LEN_ONE;
        else                  code = LEN_NONE;
    end
endmodule

// File: rtl/bre_shadow.sv
// Local copy of the remote address register plus a validity flag.
module bre_shadow
    import bre_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] shadow,
    output logic              valid
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              ok;
    } shd_t;

    shd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.addr = load_val;
            st_d.ok   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign shadow = st_q.addr;
    assign valid  = st_q.ok;
endmodule

// File: rtl/bus_req_encoder.sv
module bus_req_encoder
    import bre_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_postinc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int MAX_BYTES  = 1 + ADDR_BYTES + DATA_BYTES;
    localparam int BUF_W      = 8 * MAX_BYTES;
    localparam int HDR_W      = CMD_W + ADDR_W;
    localparam int CNT_W      = $clog2(MAX_BYTES + 1);

    typedef struct packed {
        logic [BUF_W-1:0] obuf;
        logic [CNT_W-1:0] cnt;
    } enc_t;

    enc_t st_d, st_q;

    logic [ADDR_W-1:0] shadow;
    logic              shadow_ok;
    logic [ADDR_W-1:0] base   [2];
    len_code_e         span   [2];

    assign base[0] = shadow;
    assign base[1] = '0;

    // index 0: relative to shadow, index 1: relative to zero
    for (genvar gi = 0; gi < 2; gi++) begin : g_span
        bre_span u_span (
            .target (req_addr),
            .base   (base[gi]),
            .code   (span[gi])
        );
    end

    logic              accept;
    logic              use_clear;
    len_code_e         code;
    logic [2:0]        nbytes;
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] next_shadow;
    logic [HDR_W-1:0]  hdr;
    logic [BUF_W-1:0]  dat;

    assign accept = req_valid && req_ready;

    always_comb begin
        use_clear = !shadow_ok || (len_bytes(span[1]) < len_bytes(span[0]));
        code      = use_clear ? span[1] : span[0];
        nbytes    = len_bytes(code);
        cmd       = {3'b000, code, req_postinc, req_write, use_clear};
        next_shadow = {req_addr[ADDR_W-1:8], req_addr[7:0] + {7'd0, req_postinc}};
        // left-justify the chosen address bytes behind the command
        hdr = {cmd, req_addr << (8 * (ADDR_BYTES - int'(nbytes)))};
        dat = {{(BUF_W-DATA_W){1'b0}}, req_wdata} << (8 * (ADDR_BYTES - int'(nbytes)));
    end

    bre_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (next_shadow),
        .shadow   (shadow),
        .valid    (shadow_ok)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.obuf = {hdr, {(BUF_W-HDR_W){1'b0}}} | dat;
            st_d.cnt  = CNT_W'(1 + int'(nbytes) + (req_write ? DATA_BYTES : 0));
        end else if (out_valid && out_ready) begin
            st_d.obuf = st_q.obuf << 8;
            st_d.cnt  = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = (st_q.cnt != '0);
    assign req_ready = (st_q.cnt == '0);
    assign out_data  = st_q.obuf[BUF_W-1 -: 8];
endmodule

// File: rtl/bre_checker.sv
module bre_checker
    import bre_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data
);
    localparam int DATA_BYTES = DATA_W / 8;

    logic       in_cmd_q;
    logic       seen_q;
    logic       wr_q;
    logic [3:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cmd_q <= 1'b0;
            seen_q   <= 1'b0;
            wr_q     <= 1'b0;
            left_q   <= '0;
        end else if (req_valid && req_ready) begin
            in_cmd_q <= 1'b1;
            wr_q     <= req_write;
        end else if (out_valid && out_ready) begin
            if (in_cmd_q) begin
                in_cmd_q <= 1'b0;
                seen_q   <= 1'b1;
                left_q   <= 4'({1'b0, len_bytes(len_code_e'(out_data[4:3]))})
                          + (out_data[1] ? 4'(DATA_BYTES) : 4'd0);
            end else begin
                left_q <= left_q - 4'd1;
            end
        end
    end

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && in_cmd_q) |-> (out_data[7:5] == 3'b000));

    // covers R11 too: reset clears seen_q
    p_first_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && in_cmd_q && !seen_q) |-> out_data[0]);

    p_write_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && in_cmd_q) |-> (out_data[1] == wr_q));

    p_byte_count_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !in_cmd_q) |-> (left_q != 4'd0));

    p_idle_when_ready_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !out_valid);

    p_accept_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> (left_q == 4'd0 && !in_cmd_q));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind bus_req_encoder bre_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/sim_bus_req_encoder.sv
module sim_bus_req_encoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_postinc = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;

    int checks = 0;
    int fails  = 0;
    logic [31:0] remote = '0;
    bit done = 0;

    always #5 clk = ~clk;

    bus_req_encoder u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .req_postinc(req_postinc), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request: expected command given by hand; bytes derived from R2/R3/R8.
    task automatic do_req(input logic [31:0] addr, input logic [15:0] wd, input bit wr,
                          input bit pi, input bit stall, input logic [7:0] exp_cmd);
        logic [7:0] exp_b [7];
        logic [7:0] got_b [7];
        int n, nb, got, k;
        logic [7:0] held;
        bit held_ok;
        case (exp_cmd[4:3])
            2'd0: nb = 0;
            2'd1: nb = 1;
            2'd2: nb = 2;
            default: nb = 4;
        endcase
        exp_b[0] = exp_cmd;
        for (int i = 0; i < nb; i++) exp_b[1+i] = addr[8*(nb-1-i) +: 8];
        n = 1 + nb;
        if (wr) begin
            exp_b[n] = wd[15:8];
            exp_b[n+1] = wd[7:0];
            n += 2;
        end
        @(negedge clk);
        req_addr = addr; req_wdata = wd; req_write = wr; req_postinc = pi; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready && out_valid, "R9 busy after accept", {30'd0, req_ready, out_valid}, 32'h1);
        got = 0; k = 0; held_ok = 0; held = '0;
        while (got < n && k < 100) begin
            if (held_ok)
                chk(out_valid && out_data == held, "R10 stalled byte held", {24'd0, out_data}, {24'd0, held});
            out_ready = stall ? (k % 3 != 1) : 1'b1;
            held_ok = 0;
            if (out_valid && out_ready) begin
                got_b[got] = out_data;
                got++;
            end else if (out_valid) begin
                held = out_data;
                held_ok = 1;
            end
            k++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(!out_valid && req_ready, "R9 idle after last byte", {30'd0, out_valid, req_ready}, 32'h1);
        chk(got_b[0] == exp_cmd, "R1/R5/R6 command byte", {24'd0, got_b[0]}, {24'd0, exp_cmd});
        chk(got_b[0][7:5] == 3'b000, "R1 reserved bits", {24'd0, got_b[0]}, 32'h0);
        for (int i = 1; i < n; i++)
            chk(got_b[i] == exp_b[i], "R2/R3/R8 stream byte", {24'd0, got_b[i]}, {24'd0, exp_b[i]});
        // remote register model
        if (got_b[0][0]) remote = '0;
        for (int i = 0; i < nb; i++) remote[8*(nb-1-i) +: 8] = got_b[1+i];
        chk(remote == addr, "R3 remote address", remote, addr);
        if (got_b[0][2]) remote[7:0] = remote[7:0] + 8'd1;
    endtask

    task automatic t_reset_state;
        chk(req_ready && !out_valid, "R9 reset state", {30'd0, req_ready, out_valid}, 32'h2);
    endtask

    task automatic t_first_and_repeat;
        do_req(32'h0123_4567, 16'h0, 0, 0, 0, 8'h19);   // R4 forced clear, 4 bytes
        do_req(32'h0123_4567, 16'h0, 0, 0, 0, 8'h00);   // R5 no address bytes
    endtask

    task automatic t_postinc_wrap;
        do_req(32'h0123_45fe, 16'h0, 0, 1, 0, 8'h0C);   // R5 one byte
        do_req(32'h0123_45ff, 16'h0, 0, 1, 0, 8'h04);   // R7 shadow stepped
        do_req(32'h0123_4500, 16'h0, 0, 0, 0, 8'h00);   // R7 wrap inside byte
    endtask

    task automatic t_write_stalled;
        do_req(32'h0123_4600, 16'hbabe, 1, 0, 1, 8'h12); // R8 R10 two bytes
    endtask

    task automatic t_clear_shorter;
        do_req(32'h0000_00ff, 16'h0, 0, 0, 0, 8'h09);    // R6 clear + 1 byte
        do_req(32'hffff_ffff, 16'h0001, 1, 1, 1, 8'h1E); // R2 four bytes, tie keeps no clear
        do_req(32'h0000_ff00, 16'h0, 0, 0, 0, 8'h11);    // R6 clear + 2 bytes
    endtask

    task automatic t_reset_mid;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        remote = 32'hdead_beef;                          // remote unknown after reset
        chk(req_ready && !out_valid, "R11 reset idle", {30'd0, req_ready, out_valid}, 32'h2);
        do_req(32'h0000_ff00, 16'h0, 0, 0, 0, 8'h11);    // R11 same address still clears
        do_req(32'h0000_0000, 16'h0, 0, 0, 0, 8'h01);    // R6 clear, no bytes
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_first_and_repeat();
        t_postinc_wrap();
        t_write_stalled();
        t_clear_shorter();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule